// File: doc/BRIEF.md
# Packed Integer to Single-Precision Converter

This block takes a 64-bit source word that carries two signed 32-bit integers and turns each one into an IEEE-754 single-precision value. The two results are placed in the low 64 bits of a 128-bit destination word. The upper 64 bits of that word are copied from the old destination value supplied with the operation. Integers wider than the 24-bit significand are rounded under a 2-bit rounding-control input. A single precision flag reports whether either lane lost bits.

Each operation also sets two status outputs to the values that mark the end of stack-based floating-point use. These are a zero top-of-stack pointer and a tag word that marks every register valid. The block sits in an execution pipeline. The caller presents a strobe with the operands and the rounding mode, and the result, the flag and a valid pulse come back exactly one clock later.

Top module: `pk_i2f_conv`

## Requirements
- R1: Source bits 31:0 (lane 0) are converted to an IEEE-754 single-precision value in result bits 31:0, and source bits 63:32 (lane 1) go to result bits 63:32. Both are treated as two's-complement signed integers; the output layout is sign bit 31, 8-bit biased exponent (bias 127) in bits 30:23, and 23-bit fraction in bits 22:0.
- R2: Result bits 127:64 equal bits 127:64 of the old destination input captured with the strobe.
- R3: Inexact lanes are rounded by rndCtl: 2'b00 to nearest with ties to even, 2'b01 toward minus infinity, 2'b10 toward plus infinity, 2'b11 toward zero.
- R4: When rounding carries out of the 24-bit significand, the exponent goes up by one and the fraction becomes zero (for example 0x7FFFFFFF to nearest gives 0x4F000000).
- R5: inexactOut is 1 when at least one lane's conversion was not exact, and 0 when both lanes were exact.
- R6: An integer of zero yields 0x00000000. The integer -2^31 yields 0xCF000000 and counts as exact.
- R7: After each operation fpuTopOut is 0 and fpuTagOut is 16'h0000, which marks all registers valid.
- R8: resultOut and inexactOut update exactly one clock after a cycle with inStrobe high, and outValid is high for that one cycle only. Without a strobe, resultOut and inexactOut hold their values.
- R9: A synchronous active-high rst clears resultOut, inexactOut, outValid, fpuTopOut and fpuTagOut to zero on the next clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inStrobe | input | 1 | Starts one operation with the operands on this cycle |
| srcIn | input | 64 | Two packed signed 32-bit integers |
| oldDestIn | input | 128 | Previous destination value; its upper half is kept |
| rndCtl | input | 2 | Rounding mode (see R3) |
| resultOut | output | 128 | Merged destination result |
| inexactOut | output | 1 | Precision flag, the OR of both lanes |
| outValid | output | 1 | One-cycle pulse marking a new result |
| fpuTopOut | output | 3 | Top-of-stack pointer side effect |
| fpuTagOut | output | 16 | Tag word side effect |

## Verification
A wrong leading-one position or a wrong shift shows up as a wrong exponent or fraction in resultOut one clock after the strobe. Values near a rounding boundary under each of the four modes, and values that carry into the exponent, expose faults in the round-up decision or the carry path. Because the model is compared on every clock, a missing hold, an extra valid pulse or a failed reset is seen on the very next cycle.

// File: rtl/pk_i2f_pkg.sv
package pk_i2f_pkg;
  localparam int SP_EXP_W = 8;
  localparam int SP_MAN_W = 23;
  localparam int SP_BIAS  = 127;
  localparam int SP_W     = 1 + SP_EXP_W + SP_MAN_W;

  typedef enum logic [1:0] {
    RND_NEAR = 2'b00,
    RND_DOWN = 2'b01,
    RND_UP   = 2'b10,
    RND_ZERO = 2'b11
  } rndMode_e;

  typedef struct packed {
    logic load;
    logic clear;
  } ctrlStrobes_t;
endpackage

// File: rtl/pk_i2f_lane.sv
module pk_i2f_lane
  import pk_i2f_pkg::*;
#(
  parameter int INT_W = 32
) (
  input  logic [INT_W-1:0] intIn,
  input  rndMode_e         rndMode,
  output logic [SP_W-1:0]  fpOut,
  output logic             inexact
);
  localparam int POS_W   = $clog2(INT_W);
  localparam int GUARD_I = INT_W - 2 - SP_MAN_W;

  logic                signBit;
  logic [INT_W-1:0]    mag;
  logic [POS_W-1:0]    leadPos;
  logic [POS_W-1:0]    shiftAmt;
  logic [INT_W-1:0]    norm;
  logic [SP_MAN_W-1:0] manTrunc;
  logic                guardBit;
  logic                stickyBit;
  logic                roundUp;
  logic                carry;
  logic [SP_MAN_W-1:0] manRnd;
  logic [SP_EXP_W-1:0] expVal;

  assign signBit = intIn[INT_W-1];
  assign mag     = signBit ? (~intIn + 1'b1) : intIn;

  always_comb begin
    leadPos = '0;
    for (int i = 0; i < INT_W; i++) begin
      if (mag[i]) leadPos = POS_W'(i);
    end
  end

  assign shiftAmt  = POS_W'(INT_W - 1) - leadPos;
  assign norm      = mag << shiftAmt;
  assign manTrunc  = norm[INT_W-2 -: SP_MAN_W];
  assign guardBit  = norm[GUARD_I];
  assign stickyBit = |norm[GUARD_I-1:0];
  assign inexact   = guardBit | stickyBit;

  always_comb begin
    unique case (rndMode)
      RND_NEAR: roundUp = guardBit & (stickyBit | manTrunc[0]);
      RND_DOWN: roundUp = signBit & inexact;
      RND_UP:   roundUp = ~signBit & inexact;
      default:  roundUp = 1'b0;
    endcase
  end

  assign {carry, manRnd} = {1'b0, manTrunc} + {{SP_MAN_W{1'b0}}, roundUp};
  assign expVal = SP_EXP_W'(SP_BIAS) + SP_EXP_W'(leadPos) + SP_EXP_W'(carry);
  assign fpOut  = (mag == '0) ? '0 : {signBit, expVal, manRnd};
endmodule

// File: rtl/pk_i2f_dp.sv
module pk_i2f_dp
  import pk_i2f_pkg::*;
#(
  parameter int LANES  = 2,
  parameter int INT_W  = 32,
  parameter int DEST_W = 128,
  parameter int TOP_W  = 3,
  parameter int TAG_W  = 16
) (
  input  logic                   clk,
  input  ctrlStrobes_t           ctrl,
  input  logic [LANES*INT_W-1:0] srcIn,
  input  logic [DEST_W-1:0]      oldDestIn,
  input  rndMode_e               rndMode,
  output logic [DEST_W-1:0]      resultQ,
  output logic                   inexactQ,
  output logic [TOP_W-1:0]       topQ,
  output logic [TAG_W-1:0]       tagQ
);
  localparam int PACK_W = LANES * SP_W;

  logic [PACK_W-1:0] packedFp;
  logic [LANES-1:0]  laneInexact;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    pk_i2f_lane #(.INT_W(INT_W)) u_lane (
      .intIn   (srcIn[g*INT_W +: INT_W]),
      .rndMode (rndMode),
      .fpOut   (packedFp[g*SP_W +: SP_W]),
      .inexact (laneInexact[g])
    );
  end

  always_ff @(posedge clk) begin
    if (ctrl.clear) begin
      resultQ  <= '0;
      inexactQ <= 1'b0;
      topQ     <= '0;
      tagQ     <= '0;
    end else if (ctrl.load) begin
      resultQ  <= {oldDestIn[DEST_W-1:PACK_W], packedFp};
      inexactQ <= |laneInexact;
      topQ     <= '0;
      tagQ     <= '0;
    end
  end
endmodule

// File: rtl/pk_i2f_ctrl.sv
module pk_i2f_ctrl
  import pk_i2f_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         inStrobe,
  output ctrlStrobes_t ctrl,
  output logic         validQ
);
  assign ctrl.clear = rst;
  assign ctrl.load  = inStrobe & ~rst;

  always_ff @(posedge clk) begin
    if (rst) validQ <= 1'b0;
    else     validQ <= inStrobe;
  end
endmodule

// File: rtl/pk_i2f_conv.sv
module pk_i2f_conv
  import pk_i2f_pkg::*;
#(
  parameter int LANES  = 2,
  parameter int INT_W  = 32,
  parameter int DEST_W = 128,
  parameter int TOP_W  = 3,
  parameter int TAG_W  = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   inStrobe,
  input  logic [LANES*INT_W-1:0] srcIn,
  input  logic [DEST_W-1:0]      oldDestIn,
  input  logic [1:0]             rndCtl,
  output logic [DEST_W-1:0]      resultOut,
  output logic                   inexactOut,
  output logic                   outValid,
  output logic [TOP_W-1:0]       fpuTopOut,
  output logic [TAG_W-1:0]       fpuTagOut
);
  ctrlStrobes_t ctrl;

  pk_i2f_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inStrobe (inStrobe),
    .ctrl     (ctrl),
    .validQ   (outValid)
  );

  pk_i2f_dp #(
    .LANES(LANES), .INT_W(INT_W), .DEST_W(DEST_W), .TOP_W(TOP_W), .TAG_W(TAG_W)
  ) u_dp (
    .clk       (clk),
    .ctrl      (ctrl),
    .srcIn     (srcIn),
    .oldDestIn (oldDestIn),
    .rndMode   (rndMode_e'(rndCtl)),
    .resultQ   (resultOut),
    .inexactQ  (inexactOut),
    .topQ      (fpuTopOut),
    .tagQ      (fpuTagOut)
  );
endmodule

// File: rtl/pk_i2f_chk.sv
module pk_i2f_chk (
  input logic         clk,
  input logic         rst,
  input logic         inStrobe,
  input logic [63:0]  srcIn,
  input logic [127:0] oldDestIn,
  input logic [127:0] resultOut,
  input logic         inexactOut,
  input logic         outValid
);
  // R8: valid pulse one clock after the strobe
  a_r8_valid_after_strobe: assert property (@(posedge clk) disable iff (rst)
    inStrobe |=> outValid);
  // R8: no valid without a strobe
  a_r8_valid_single: assert property (@(posedge clk) disable iff (rst)
    !inStrobe |=> !outValid);
  // R8: results hold between operations
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    !inStrobe |=> ($stable(resultOut) && $stable(inexactOut)));
  // R2: upper half copied from the old destination
  a_r2_upper_keep: assert property (@(posedge clk) disable iff (rst)
    inStrobe |=> resultOut[127:64] == $past(oldDestIn[127:64]));
  // R6: zero converts to positive zero
  a_r6_zero_lane0: assert property (@(posedge clk) disable iff (rst)
    (inStrobe && srcIn[31:0] == 32'd0) |=> resultOut[31:0] == 32'd0);
  // R5: small magnitudes are exact in both lanes
  a_r5_small_exact: assert property (@(posedge clk) disable iff (rst)
    (inStrobe && srcIn[31:16] == 16'd0 && srcIn[63:48] == 16'd0) |=> !inexactOut);
  // R1: negative lane 1 gives a negative result
  a_r1_sign_lane1: assert property (@(posedge clk) disable iff (rst)
    (inStrobe && srcIn[63]) |=> resultOut[63]);
endmodule

bind pk_i2f_conv pk_i2f_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .inStrobe   (inStrobe),
  .srcIn      (srcIn),
  .oldDestIn  (oldDestIn),
  .resultOut  (resultOut),
  .inexactOut (inexactOut),
  .outValid   (outValid)
);

// File: tb/tb_pk_i2f_conv.sv
`timescale 1ns/1ps
module tb_pk_i2f_conv;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         inStrobe = 1'b0;
  logic [63:0]  srcIn = '0;
  logic [127:0] oldDestIn = '0;
  logic [1:0]   rndCtl = '0;
  logic [127:0] resultOut;
  logic         inexactOut, outValid;
  logic [2:0]   fpuTopOut;
  logic [15:0]  fpuTagOut;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pk_i2f_conv dut (
    .clk(clk), .rst(rst), .inStrobe(inStrobe), .srcIn(srcIn),
    .oldDestIn(oldDestIn), .rndCtl(rndCtl), .resultOut(resultOut),
    .inexactOut(inexactOut), .outValid(outValid),
    .fpuTopOut(fpuTopOut), .fpuTagOut(fpuTagOut)
  );

  // behavioural reference: integer division into kept bits and remainder
  task automatic refConv(input logic [31:0] v, input logic [1:0] rm,
                         output logic [31:0] bits, output bit inex);
    longint mag, q, rem, half;
    int e, sh;
    bit s, up;
    if (v == 32'd0) begin
      bits = 32'd0; inex = 0;
      return;
    end
    s = v[31];
    mag = longint'($signed(v));
    if (s) mag = -mag;
    e = 0;
    while ((mag >> (e + 1)) != 0) e++;
    if (e <= 23) begin
      q = mag << (23 - e); rem = 0; half = 1;
    end else begin
      sh = e - 23;
      q = mag >> sh;
      rem = mag - (q << sh);
      half = longint'(1) << (sh - 1);
    end
    inex = (rem != 0);
    case (rm)
      2'b00:   up = (rem > half) || (inex && rem == half && q[0]);
      2'b01:   up = s && inex;
      2'b10:   up = !s && inex;
      default: up = 0;
    endcase
    if (up) q = q + 1;
    if (q == (longint'(1) << 24)) begin
      q = longint'(1) << 23; e++;
    end
    bits = {s, 8'(e + 127), q[22:0]};
  endtask

  logic [127:0] expRes = '0;
  logic         expFlag = 0, expValid = 0;

  always @(posedge clk) begin
    logic [31:0] b0, b1;
    bit i0, i1;
    if (rst) begin
      expRes <= '0; expFlag <= 0; expValid <= 0;
    end else begin
      expValid <= inStrobe;
      if (inStrobe) begin
        refConv(srcIn[31:0], rndCtl, b0, i0);
        refConv(srcIn[63:32], rndCtl, b1, i1);
        expRes  <= {oldDestIn[127:64], b1, b0};
        expFlag <= i0 | i1;
      end
    end
  end

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic compareAll();
    chk("R1 lane0", 128'(resultOut[31:0]), 128'(expRes[31:0]));
    chk("R1 lane1", 128'(resultOut[63:32]), 128'(expRes[63:32]));
    chk("R2 upper", 128'(resultOut[127:64]), 128'(expRes[127:64]));
    chk("R5 flag", 128'(inexactOut), 128'(expFlag));
    chk("R8 valid", 128'(outValid), 128'(expValid));
    chk("R7 top", 128'(fpuTopOut), 128'(0));
    chk("R7 tag", 128'(fpuTagOut), 128'(0));
  endtask

  task automatic drive(input bit r, input bit s, input logic [63:0] src,
                       input logic [127:0] old, input logic [1:0] rm);
    @(negedge clk);
    compareAll();
    rst = r; inStrobe = s; srcIn = src; oldDestIn = old; rndCtl = rm;
  endtask

  // one operation, then an idle cycle; returns with the result on the ports
  task automatic op(input logic [63:0] src, input logic [1:0] rm);
    drive(0, 1, src, {$urandom, $urandom, $urandom, $urandom}, rm);
    drive(0, 0, '0, '0, 2'b00);
  endtask

  task automatic lit(input string req, input logic [31:0] e0, input logic [31:0] e1, input bit ef);
    chk(req, 128'(resultOut[31:0]), 128'(e0));
    chk(req, 128'(resultOut[63:32]), 128'(e1));
    chk(req, 128'(inexactOut), 128'(ef));
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog act=%0d exp=<50000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    drive(1, 0, '0, '0, 2'b00);
    drive(0, 0, '0, '0, 2'b00);
    // R9 reset state
    chk("R9 reset result", resultOut, '0);
    chk("R9 reset valid", 128'(outValid), 128'(0));

    // R6 zero and most negative integer
    op({32'h80000000, 32'h00000000}, 2'b00);
    lit("R6 zero/minint", 32'h00000000, 32'hCF000000, 0);
    // R1 simple values
    op({32'hFFFFFFFF, 32'h00000001}, 2'b00);
    lit("R1 one/minus one", 32'h3F800000, 32'hBF800000, 0);
    // R3 each mode on 2^24+1 and its negation
    op({32'hFEFFFFFF, 32'h01000001}, 2'b00);
    lit("R3 nearest tie", 32'h4B800000, 32'hCB800000, 1);
    op({32'hFEFFFFFF, 32'h01000001}, 2'b01);
    lit("R3 down", 32'h4B800000, 32'hCB800001, 1);
    op({32'hFEFFFFFF, 32'h01000001}, 2'b10);
    lit("R3 up", 32'h4B800001, 32'hCB800000, 1);
    op({32'hFEFFFFFF, 32'h01000001}, 2'b11);
    lit("R3 zero", 32'h4B800000, 32'hCB800000, 1);
    op({32'h00000000, 32'h01000003}, 2'b00);
    lit("R3 tie to even up", 32'h4B800002, 32'h00000000, 1);
    // R4 carry out of significand
    op({32'h80000001, 32'h7FFFFFFF}, 2'b00);
    lit("R4 carry nearest", 32'h4F000000, 32'hCF000000, 1);
    op({32'h80000001, 32'h7FFFFFFF}, 2'b11);
    lit("R4 no carry zero", 32'h4EFFFFFF, 32'hCEFFFFFF, 1);
    // R5 only one lane inexact
    op({32'h7FFFFFFF, 32'h00000005}, 2'b11);
    lit("R5 one lane", 32'h40A00000, 32'h4EFFFFFF, 1);
    // R8 hold over several idle cycles
    drive(0, 0, 64'hFFFF_FFFF_FFFF_FFFF, '1, 2'b10);
    lit("R8 hold", 32'h40A00000, 32'h4EFFFFFF, 1);
    chk("R8 no valid", 128'(outValid), 128'(0));

    // random traffic
    for (int i = 0; i < 400; i++) begin
      drive(0, ($urandom % 3) != 0, {$urandom, $urandom},
            {$urandom, $urandom, $urandom, $urandom}, 2'($urandom));
    end

    // R9 reset after an operation
    drive(0, 1, {32'h12345678, 32'h9ABCDEF0}, '1, 2'b00);
    drive(1, 0, '0, '0, 2'b00);
    drive(0, 0, '0, '0, 2'b00);
    chk("R9 clear result", resultOut, '0);
    chk("R9 clear flag", 128'(inexactOut), 128'(0));
    chk("R9 clear valid", 128'(outValid), 128'(0));
    drive(0, 0, '0, '0, 2'b00);

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule